// File: doc/BRIEF.md
# Carry-Select Adder with Increment Converters

This block adds two 16-bit operands and a carry-in, and returns a 16-bit sum with a carry-out. It is purely combinational, so the outputs follow the inputs within the same cycle. It is meant for datapaths where an adder sits in a timing-critical path, such as the partial-product summation stage of a multiplier.

The operand bits are split into five slices of growing width: 2, 2, 3, 4 and 5 bits, starting at bit 0. The slice widths come from a single base parameter. The lowest slice is a plain ripple adder fed by the external carry-in.

Each upper slice works in three steps:
- One ripple adder computes the slice result as if its carry-in were zero. This result includes the slice's own carry bit.
- An increment converter, made only of XOR, AND and NOT gates, derives the carry-in-one result by adding one to that value.
- The carry arriving from the slice below selects which of the two results leaves the slice, and the carry bit of the selected result feeds the next slice.

A classic carry-select design uses a second ripple adder for the carry-in-one result. This design replaces it with the cheaper increment converter.

Top module: `csel_inc_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals the 17-bit value `op_a + op_b + carry_in` for every input combination.
- R2: With `op_a` and `op_b` held, raising `carry_in` from 0 to 1 raises the 17-bit result by exactly one. This includes the case where the increment ripples through every slice into `carry_o`.
- R3: Each increment converter returns its (slice width + 1)-bit input plus one. Bit 0 is the inverse of input bit 0, and every higher bit k is input bit k XOR the AND of all lower input bits.
- R4: In each upper slice, a carry of 1 from below selects the converter result and a carry of 0 selects the carry-in-zero ripple result. The selected value's top bit is that slice's carry-out.
- R5: The carry-in-zero result of a slice (sum bits plus carry bit) is never all ones, so the converter never wraps. This holds even with both operands all ones.
- R6: A carry generated at the bottom reaches any bit position k (1 to 16). With `op_a` = 2^k−1, `op_b` = 0 and `carry_in` = 1, the result is exactly 2^k, across every slice boundary.
- R7: The outputs depend only on the present inputs. A change of inputs is reflected at the outputs without any clock edge, and no state is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
The bench applies several kinds of input, each aimed at a different failure.

All-zero and all-ones operands with both carry-in values separate a correct adder from one whose converter wraps or whose select polarity is swapped. Alternating 1010/0101 patterns make every slice either fully propagate or fully generate. A walking carry chain (2^k−1 plus carry-in) stops a carry at each slice boundary in turn, which exposes wrong slice offsets or a broken carry hand-off. Pseudo-random vectors with both carry-in values cover mixed generate, propagate and kill conditions.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Natural width of slice i: slices 0 and 1 take the base width, then grow by one.
  function automatic int nat_w(input int i, input int base);
    return (i == 0) ? base : base + i - 1;
  endfunction

  // Lowest bit index of slice i.
  function automatic int grp_lo(input int i, input int base);
    int lo;
    lo = 0;
    for (int j = 0; j < i; j++) lo += nat_w(j, base);
    return lo;
  endfunction

  // Number of slices needed to cover width bits.
  function automatic int num_grps(input int width, input int base);
    int lo;
    int n;
    lo = 0;
    n  = 0;
    while (lo < width) begin
      lo += nat_w(n, base);
      n++;
    end
    return n;
  endfunction

  // Actual width of slice i; the top slice is clipped to the total width.
  function automatic int grp_w(input int i, input int width, input int base);
    int lo;
    int w;
    lo = grp_lo(i, base);
    w  = nat_w(i, base);
    return (lo + w > width) ? (width - lo) : w;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign s[k]   = a[k] ^ b[k] ^ c[k];
    assign c[k+1] = (a[k] & b[k]) | (c[k] & (a[k] ^ b[k]));
  end

  assign co = c[W];

  always_comb begin
    AST_RIPPLE_SUM: assert ({co, s} == ((W+1)'(a) + (W+1)'(b) + (W+1)'(ci)))
      else $error("ripple slice result mismatch"); // R1
  end

endmodule

// File: rtl/csel_incr.sv
module csel_incr #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  logic [W-1:0] all_low;

  assign all_low[0] = 1'b1;
  assign y[0]       = ~x[0];

  for (genvar k = 1; k < W; k++) begin : g_bit
    assign all_low[k] = all_low[k-1] & x[k-1];
    assign y[k]       = x[k] ^ all_low[k];
  end

  always_comb begin
    AST_INCR_PLUS_ONE: assert (y == x + W'(1))
      else $error("increment converter mismatch"); // R3
  end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int XW = W + 1;

  logic [W-1:0]  s_zero;
  logic          c_zero;
  logic [XW-1:0] v_zero;
  logic [XW-1:0] v_one;

  csel_ripple #(.W(W)) u_rca (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (s_zero),
    .co (c_zero)
  );

  assign v_zero = {c_zero, s_zero};

  csel_incr #(.W(XW)) u_inc (
    .x (v_zero),
    .y (v_one)
  );

  assign {co, s} = sel ? v_one : v_zero;

  always_comb begin
    AST_NO_WRAP: assert (v_zero != {XW{1'b1}})
      else $error("carry-in-zero slice value is all ones"); // R5
    if (sel) begin
      AST_SEL_ONE: assert ({co, s} == (XW'(a) + XW'(b) + XW'(1)))
        else $error("slice result wrong with carry one"); // R4
    end else begin
      AST_SEL_ZERO: assert ({co, s} == (XW'(a) + XW'(b)))
        else $error("slice result wrong with carry zero"); // R4
    end
  end

endmodule

// File: rtl/csel_inc_adder.sv
module csel_inc_adder #(
  parameter int WIDTH = 16,
  parameter int BASE  = 2
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int NG = csel_pkg::num_grps(WIDTH, BASE);

  logic [NG:0] gc;

  assign gc[0] = carry_in;

  for (genvar g = 0; g < NG; g++) begin : g_slice
    localparam int LO = csel_pkg::grp_lo(g, BASE);
    localparam int GW = csel_pkg::grp_w(g, WIDTH, BASE);
    if (g == 0) begin : g_base
      csel_ripple #(.W(GW)) u_rca (
        .a  (op_a[LO +: GW]),
        .b  (op_b[LO +: GW]),
        .ci (gc[0]),
        .s  (sum_o[LO +: GW]),
        .co (gc[1])
      );
    end else begin : g_sel
      csel_group #(.W(GW)) u_grp (
        .a   (op_a[LO +: GW]),
        .b   (op_b[LO +: GW]),
        .sel (gc[g]),
        .s   (sum_o[LO +: GW]),
        .co  (gc[g+1])
      );
    end
  end

  assign carry_o = gc[NG];

  always_comb begin
    AST_TOTAL_SUM: assert ({carry_o, sum_o} ==
                           ((WIDTH+1)'(op_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in)))
      else $error("adder result mismatch"); // R1
  end

endmodule

// File: tb/csel_inc_adder_tb.sv
module csel_inc_adder_tb;

  logic        clk;
  logic        rst;
  logic [15:0] a;
  logic [15:0] b;
  logic        ci;
  logic [15:0] s;
  logic        co;

  int checks;
  int fails;
  int cycles;
  bit done;

  csel_inc_adder u_dut (
    .op_a     (a),
    .op_b     (b),
    .carry_in (ci),
    .sum_o    (s),
    .carry_o  (co)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {16'b0, c};
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] x, input logic [15:0] y,
                       input logic c);
    @(negedge clk);
    a  = x;
    b  = y;
    ci = c;
    #1;
    check(req, {co, s}, model(x, y, c));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    #1;
    check("R7 reset state zero", {co, s}, 17'h0);
  endtask

  task automatic t_corners;
    apply("R1 zero", 16'h0000, 16'h0000, 1'b0);
    apply("R2 zero plus carry", 16'h0000, 16'h0000, 1'b1);
    apply("R5 all ones", 16'hFFFF, 16'hFFFF, 1'b0);
    apply("R5 all ones with carry", 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R2 full ripple", 16'hFFFF, 16'h0000, 1'b1);
    apply("R2 full ripple b", 16'h0000, 16'hFFFF, 1'b1);
    apply("R3 slice values all ones", 16'hFFFC, 16'h0003, 1'b1);
  endtask

  task automatic t_alternating;
    apply("R4 alt propagate", 16'hAAAA, 16'h5555, 1'b0);
    apply("R4 alt propagate carry", 16'hAAAA, 16'h5555, 1'b1);
    apply("R4 alt generate", 16'hAAAA, 16'hAAAA, 1'b0);
    apply("R4 alt generate b", 16'h5555, 16'h5555, 1'b1);
  endtask

  task automatic t_chain;
    for (int k = 1; k <= 16; k++) begin
      logic [16:0] mask;
      mask = (17'h1 << k) - 17'h1;
      apply("R6 walking carry", mask[15:0], 16'h0000, 1'b1);
      check("R6 carry lands at bit k", {co, s}, 17'h1 << k);
    end
  endtask

  task automatic t_comb;
    logic [16:0] first;
    apply("R7 first value", 16'h1234, 16'h4321, 1'b0);
    first = {co, s};
    a = 16'h8000;
    b = 16'h8000;
    ci = 1'b1;
    #1;
    check("R7 no clock needed", {co, s}, 17'h10001);
    check("R7 prior value", first, 17'h05555);
  endtask

  task automatic t_random;
    logic [31:0] seed;
    seed = 32'h1ACE_2B0D;
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] x;
      logic [15:0] y;
      logic [16:0] r0;
      seed = seed * 32'd1664525 + 32'd1013904223;
      x = seed[31:16];
      seed = seed * 32'd1664525 + 32'd1013904223;
      y = seed[31:16];
      apply("R1 random", x, y, 1'b0);
      r0 = {co, s};
      apply("R1 random carry", x, y, 1'b1);
      check("R2 carry adds one", {co, s}, r0 + 17'h1);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    cycles = 0;
    done   = 1'b0;
    a   = '0;
    b   = '0;
    ci  = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_corners();
    t_alternating();
    t_chain();
    t_comb();
    t_random();
    done = 1'b1;
    finish_run();
  end

endmodule